// File: doc/BRIEF.md
# TLB Fault Exception Capture

This block sits beside an address-translation unit. When a translation attempt ends, the block receives the result class, the virtual address that was looked up, and whether the access was a store. If the strobe is high and the result is anything other than a hit, the block works out which exception to raise. It also records the fault state: the full bad address, a page-table context word and an entry-high word. Software later uses that state to find and refill the missing translation.

A missing translation and an invalid entry raise the same exception code. The block separates them with a refill flag, so the vectoring logic downstream can choose the fast refill handler. The context and entry-high values come from their current contents, supplied on input ports. Fields the fault does not own are carried across unchanged.

All outputs are registered. They change on the clock edge that samples the strobe and otherwise hold their value.

Top module: `tlb_fault_capture`

## Requirements
- R1: Result code 1 (address error), and also any undefined code 5 to 7, gives exc_code 5 for a store and 4 for a load, with exc_refill low.
- R2: Result code 2 (no matching entry) gives exc_code 3 for a store and 2 for a load, with exc_refill high.
- R3: Result code 3 (entry not valid) gives the same codes as R2 (3 store, 2 load), with exc_refill low.
- R4: Result code 4 (write to a clean page) gives exc_code 1 for both loads and stores, with exc_refill low.
- R5: On a taken fault, badvaddr_q takes the full faulting virtual address.
- R6: On a taken fault, context_q bits 31:23 come from ctx_cur bits 31:23, bits 22:4 come from address bits 31:13, and bits 3:0 are zero.
- R7: On a taken fault, entryhi_q bits 31:13 come from address bits 31:13, bits 12:8 are zero, and bits 7:0 come from ehi_cur bits 7:0.
- R8: A strobe carrying result code 0 (hit), or a cycle with no strobe, leaves exc_valid low and keeps exc_code, exc_refill, badvaddr_q, context_q and entryhi_q at their previous values.
- R9: After reset, every output is zero.
- R10: exc_valid is high for exactly the one cycle after each taken fault. Back-to-back faults each update the outputs on the edge that samples them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flt_strobe | input | 1 | Translation result is present this cycle |
| flt_result | input | 3 | Result class: 0 hit, 1 address error, 2 no match, 3 invalid, 4 clean-page write |
| flt_vaddr | input | 32 | Virtual address that was translated |
| flt_store | input | 1 | 1 for a store, 0 for a load |
| ctx_cur | input | 32 | Current context register contents |
| ehi_cur | input | 32 | Current entry-high register contents |
| exc_valid | output | 1 | One-cycle pulse for a raised exception |
| exc_code | output | 5 | Exception cause code |
| exc_refill | output | 1 | Fault came from a missing translation |
| badvaddr_q | output | 32 | Captured faulting address |
| context_q | output | 32 | Updated context word |
| entryhi_q | output | 32 | Updated entry-high word |

## Verification
The properties assume that the result code, address, direction and current register inputs are stable and meaningful whenever the strobe is high. When the strobe is low the properties treat those inputs as don't-care. The bench changes inputs only on the falling clock edge and holds them until the next one. It also drives different garbage values when the strobe is low, so a design that ignores the strobe would show it. The context and entry-high properties read the current-register inputs one cycle back. This only works because the bench never changes them in the middle of a sampled cycle.

// File: rtl/tlbf_pkg.sv
package tlbf_pkg;
  localparam int RES_W = 3;
  localparam int EXC_W = 5;

  localparam logic [RES_W-1:0] RES_HIT      = 3'd0;
  localparam logic [RES_W-1:0] RES_ADDR_ERR = 3'd1;
  localparam logic [RES_W-1:0] RES_MISS     = 3'd2;
  localparam logic [RES_W-1:0] RES_INVALID  = 3'd3;
  localparam logic [RES_W-1:0] RES_DIRTY    = 3'd4;

  localparam logic [EXC_W-1:0] EXC_MOD  = 5'd1;
  localparam logic [EXC_W-1:0] EXC_TLBL = 5'd2;
  localparam logic [EXC_W-1:0] EXC_TLBS = 5'd3;
  localparam logic [EXC_W-1:0] EXC_ADEL = 5'd4;
  localparam logic [EXC_W-1:0] EXC_ADES = 5'd5;

  typedef struct packed {
    logic             raise;
    logic [EXC_W-1:0] code;
    logic             refill;
  } fault_cause_t;
endpackage

// File: rtl/tlbf_cause_decode.sv
module tlbf_cause_decode
  import tlbf_pkg::*;
(
  input  logic [RES_W-1:0] result,
  input  logic             is_store,
  output fault_cause_t     cause
);
  logic is_addr_err, is_miss, is_invalid, is_dirty, is_hit;

  always_comb begin
    is_hit      = (result == RES_HIT);
    is_miss     = (result == RES_MISS);
    is_invalid  = (result == RES_INVALID);
    is_dirty    = (result == RES_DIRTY);
    is_addr_err = !(is_hit || is_miss || is_invalid || is_dirty);
  end

  always_comb begin
    cause.raise  = !is_hit;
    cause.refill = is_miss;
    if (is_dirty)
      cause.code = EXC_MOD;
    else if (is_miss || is_invalid)
      cause.code = is_store ? EXC_TLBS : EXC_TLBL;
    else if (is_addr_err)
      cause.code = is_store ? EXC_ADES : EXC_ADEL;
    else
      cause.code = '0;
  end
endmodule

// File: rtl/tlbf_reg_merge.sv
module tlbf_reg_merge #(
  parameter int VA_W     = 32,
  parameter int ASID_W   = 8,
  parameter int PAGE_LSB = 13,
  parameter int CTX_LSB  = 4
) (
  input  logic [VA_W-1:0] vaddr,
  input  logic [VA_W-1:0] ctx_old,
  input  logic [VA_W-1:0] ehi_old,
  output logic [VA_W-1:0] ctx_new,
  output logic [VA_W-1:0] ehi_new
);
  localparam int VPN_W  = VA_W - PAGE_LSB;
  localparam int CTX_HI = CTX_LSB + VPN_W - 1;

  function automatic logic [VA_W-1:0] pack_context(input logic [VA_W-1:0] old_v,
                                                   input logic [VA_W-1:0] va);
    logic [VA_W-1:0] r;
    r = old_v;
    r[CTX_HI:0] = '0;
    r[CTX_HI:CTX_LSB] = va[VA_W-1:PAGE_LSB];
    return r;
  endfunction

  function automatic logic [VA_W-1:0] pack_entryhi(input logic [VA_W-1:0] old_v,
                                                   input logic [VA_W-1:0] va);
    logic [VA_W-1:0] r;
    r = va;
    r[PAGE_LSB-1:0] = '0;
    r[ASID_W-1:0] = old_v[ASID_W-1:0];
    return r;
  endfunction

  always_comb begin
    ctx_new = pack_context(ctx_old, vaddr);
    ehi_new = pack_entryhi(ehi_old, vaddr);
  end
endmodule

// File: rtl/tlb_fault_capture.sv
module tlb_fault_capture
  import tlbf_pkg::*;
#(
  parameter int VA_W     = 32,
  parameter int ASID_W   = 8,
  parameter int PAGE_LSB = 13,
  parameter int CTX_LSB  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flt_strobe,
  input  logic [RES_W-1:0] flt_result,
  input  logic [VA_W-1:0]  flt_vaddr,
  input  logic             flt_store,
  input  logic [VA_W-1:0]  ctx_cur,
  input  logic [VA_W-1:0]  ehi_cur,
  output logic             exc_valid,
  output logic [EXC_W-1:0] exc_code,
  output logic             exc_refill,
  output logic [VA_W-1:0]  badvaddr_q,
  output logic [VA_W-1:0]  context_q,
  output logic [VA_W-1:0]  entryhi_q
);
  fault_cause_t    cause;
  logic [VA_W-1:0] ctx_next, ehi_next;
  logic            fault_take;

  tlbf_cause_decode u_dec (
    .result   (flt_result),
    .is_store (flt_store),
    .cause    (cause)
  );

  tlbf_reg_merge #(
    .VA_W(VA_W), .ASID_W(ASID_W), .PAGE_LSB(PAGE_LSB), .CTX_LSB(CTX_LSB)
  ) u_merge (
    .vaddr   (flt_vaddr),
    .ctx_old (ctx_cur),
    .ehi_old (ehi_cur),
    .ctx_new (ctx_next),
    .ehi_new (ehi_next)
  );

  assign fault_take = flt_strobe && cause.raise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exc_valid  <= 1'b0;
      exc_code   <= '0;
      exc_refill <= 1'b0;
      badvaddr_q <= '0;
      context_q  <= '0;
      entryhi_q  <= '0;
    end else begin
      exc_valid <= fault_take;
      if (fault_take) begin
        exc_code   <= cause.code;
        exc_refill <= cause.refill;
        badvaddr_q <= flt_vaddr;
        context_q  <= ctx_next;
        entryhi_q  <= ehi_next;
      end
    end
  end
endmodule

// File: rtl/tlbf_checker.sv
module tlbf_checker
  import tlbf_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             flt_strobe,
  input logic [RES_W-1:0] flt_result,
  input logic [31:0]      flt_vaddr,
  input logic             flt_store,
  input logic [31:0]      ctx_cur,
  input logic [31:0]      ehi_cur,
  input logic             fault_take,
  input logic             exc_valid,
  input logic [EXC_W-1:0] exc_code,
  input logic             exc_refill,
  input logic [31:0]      badvaddr_q,
  input logic [31:0]      context_q,
  input logic [31:0]      entryhi_q
);
  p_addr_err_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_strobe && flt_result == RES_ADDR_ERR) |=>
      (exc_code == ($past(flt_store) ? EXC_ADES : EXC_ADEL)) && !exc_refill);

  p_miss_refill_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_strobe && flt_result == RES_MISS) |=> exc_refill && exc_valid);

  p_invalid_norefill_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_strobe && flt_result == RES_INVALID) |=>
      !exc_refill && (exc_code == EXC_TLBL || exc_code == EXC_TLBS));

  p_dirty_mod_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_strobe && flt_result == RES_DIRTY) |=> exc_code == EXC_MOD);

  p_badaddr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fault_take |=> badvaddr_q == $past(flt_vaddr));

  p_context_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fault_take |=> (context_q[3:0] == 4'd0) &&
                   (context_q[31:23] == $past(ctx_cur[31:23])) &&
                   (context_q[22:4] == $past(flt_vaddr[31:13])));

  p_entryhi_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fault_take |=> (entryhi_q[7:0] == $past(ehi_cur[7:0])) &&
                   (entryhi_q[12:8] == 5'd0) &&
                   (entryhi_q[31:13] == $past(flt_vaddr[31:13])));

  p_hit_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(flt_strobe && flt_result != RES_HIT) |=>
      !exc_valid && $stable(badvaddr_q) && $stable(context_q) &&
      $stable(entryhi_q) && $stable(exc_code) && $stable(exc_refill));

  p_refill_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && exc_refill) |-> (exc_code == EXC_TLBL || exc_code == EXC_TLBS));
endmodule

bind tlb_fault_capture tlbf_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .flt_strobe (flt_strobe),
  .flt_result (flt_result),
  .flt_vaddr  (flt_vaddr),
  .flt_store  (flt_store),
  .ctx_cur    (ctx_cur),
  .ehi_cur    (ehi_cur),
  .fault_take (fault_take),
  .exc_valid  (exc_valid),
  .exc_code   (exc_code),
  .exc_refill (exc_refill),
  .badvaddr_q (badvaddr_q),
  .context_q  (context_q),
  .entryhi_q  (entryhi_q)
);

// File: tb/tlb_fault_capture_test.sv
module tlb_fault_capture_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flt_strobe = 1'b0;
  logic [2:0]  flt_result = 3'd0;
  logic [31:0] flt_vaddr = '0;
  logic        flt_store = 1'b0;
  logic [31:0] ctx_cur = '0;
  logic [31:0] ehi_cur = '0;
  logic        exc_valid, exc_refill;
  logic [4:0]  exc_code;
  logic [31:0] badvaddr_q, context_q, entryhi_q;

  int n_checks = 0;
  int n_fails  = 0;

  always #5 clk = ~clk;

  tlb_fault_capture uut (
    .clk(clk), .rst_n(rst_n), .flt_strobe(flt_strobe), .flt_result(flt_result),
    .flt_vaddr(flt_vaddr), .flt_store(flt_store), .ctx_cur(ctx_cur), .ehi_cur(ehi_cur),
    .exc_valid(exc_valid), .exc_code(exc_code), .exc_refill(exc_refill),
    .badvaddr_q(badvaddr_q), .context_q(context_q), .entryhi_q(entryhi_q)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive one strobed cycle at a falling edge, then scramble idle inputs;
  // the registered outputs are sampled at the following falling edge.
  task automatic strobe(input logic [2:0] res, input logic [31:0] va, input logic st,
                        input logic [31:0] c, input logic [31:0] e);
    @(negedge clk);
    flt_strobe = 1'b1; flt_result = res; flt_vaddr = va; flt_store = st;
    ctx_cur = c; ehi_cur = e;
    @(negedge clk);
    flt_strobe = 1'b0; flt_result = 3'd2; flt_vaddr = ~va; flt_store = ~st;
    ctx_cur = ~c; ehi_cur = ~e;
  endtask

  function automatic logic [31:0] want_ctx(input logic [31:0] c, input logic [31:0] va);
    return (c & 32'hFF80_0000) | ((va >> 9) & 32'h007F_FFF0);
  endfunction
  function automatic logic [31:0] want_ehi(input logic [31:0] e, input logic [31:0] va);
    return (e & 32'h0000_00FF) | (va & 32'hFFFF_E000);
  endfunction

  task automatic check_fault(input string req, input logic [31:0] va, input logic [31:0] c,
                             input logic [31:0] e, input logic [4:0] code, input logic rf);
    chk({req, " exc_valid"}, {31'd0, exc_valid}, 32'd1);
    chk({req, " exc_code"}, {27'd0, exc_code}, {27'd0, code});
    chk({req, " exc_refill"}, {31'd0, exc_refill}, {31'd0, rf});
    chk("R5 badvaddr", badvaddr_q, va);
    chk("R6 context", context_q, want_ctx(c, va));
    chk("R7 entryhi", entryhi_q, want_ehi(e, va));
  endtask

  task automatic t_reset;
    chk("R9 exc_valid", {31'd0, exc_valid}, 32'd0);
    chk("R9 exc_code", {27'd0, exc_code}, 32'd0);
    chk("R9 exc_refill", {31'd0, exc_refill}, 32'd0);
    chk("R9 badvaddr", badvaddr_q, 32'd0);
    chk("R9 context", context_q, 32'd0);
    chk("R9 entryhi", entryhi_q, 32'd0);
  endtask

  task automatic t_addr_err;
    strobe(3'd1, 32'h8000_1234, 1'b1, 32'hA5A5_A5A5, 32'h1234_5678);
    check_fault("R1 store", 32'h8000_1234, 32'hA5A5_A5A5, 32'h1234_5678, 5'd5, 1'b0);
    strobe(3'd1, 32'hC001_F00D, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    check_fault("R1 load", 32'hC001_F00D, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd4, 1'b0);
    for (int k = 5; k < 8; k++) begin
      strobe(k[2:0], 32'h0000_2000 * k, k[0], 32'h0, 32'h0);
      check_fault("R1 undefined", 32'h0000_2000 * k, 32'h0, 32'h0,
                  k[0] ? 5'd5 : 5'd4, 1'b0);
    end
  endtask

  task automatic t_miss;
    strobe(3'd2, 32'h0040_6ABC, 1'b0, 32'h1234_0000, 32'hDEAD_BE42);
    check_fault("R2 load", 32'h0040_6ABC, 32'h1234_0000, 32'hDEAD_BE42, 5'd2, 1'b1);
    strobe(3'd2, 32'hFFFF_FFFF, 1'b1, 32'h0, 32'h0000_00AA);
    check_fault("R2 store", 32'hFFFF_FFFF, 32'h0, 32'h0000_00AA, 5'd3, 1'b1);
  endtask

  task automatic t_invalid;
    strobe(3'd3, 32'h7FFF_E001, 1'b0, 32'hFF80_000F, 32'h0000_1F01);
    check_fault("R3 load", 32'h7FFF_E001, 32'hFF80_000F, 32'h0000_1F01, 5'd2, 1'b0);
    strobe(3'd3, 32'h1357_9BDF, 1'b1, 32'h007F_FFFF, 32'hFFFF_E000);
    check_fault("R3 store", 32'h1357_9BDF, 32'h007F_FFFF, 32'hFFFF_E000, 5'd3, 1'b0);
  endtask

  task automatic t_dirty;
    strobe(3'd4, 32'h2468_ACE0, 1'b1, 32'h5555_5555, 32'hAAAA_AAAA);
    check_fault("R4 store", 32'h2468_ACE0, 32'h5555_5555, 32'hAAAA_AAAA, 5'd1, 1'b0);
    strobe(3'd4, 32'h0000_0000, 1'b0, 32'h0, 32'h0);
    check_fault("R4 load", 32'h0000_0000, 32'h0, 32'h0, 5'd1, 1'b0);
  endtask

  task automatic t_hold;
    strobe(3'd2, 32'h0ABC_D000, 1'b1, 32'h8000_0000, 32'h0000_0011);
    check_fault("R8 setup", 32'h0ABC_D000, 32'h8000_0000, 32'h0000_0011, 5'd3, 1'b1);
    strobe(3'd0, 32'h1111_1111, 1'b0, 32'h2222_2222, 32'h3333_3333);
    chk("R8 hit exc_valid", {31'd0, exc_valid}, 32'd0);
    chk("R8 hit exc_code", {27'd0, exc_code}, 32'd3);
    chk("R8 hit refill", {31'd0, exc_refill}, 32'd1);
    chk("R8 hit badvaddr", badvaddr_q, 32'h0ABC_D000);
    chk("R8 hit context", context_q, want_ctx(32'h8000_0000, 32'h0ABC_D000));
    chk("R8 hit entryhi", entryhi_q, want_ehi(32'h0000_0011, 32'h0ABC_D000));
    repeat (3) @(negedge clk);
    chk("R8 idle exc_valid", {31'd0, exc_valid}, 32'd0);
    chk("R8 idle badvaddr", badvaddr_q, 32'h0ABC_D000);
    chk("R8 idle entryhi", entryhi_q, want_ehi(32'h0000_0011, 32'h0ABC_D000));
  endtask

  task automatic t_back_to_back;
    @(negedge clk);
    flt_strobe = 1'b1; flt_result = 3'd3; flt_vaddr = 32'h0001_2000; flt_store = 1'b0;
    ctx_cur = 32'h0; ehi_cur = 32'h0000_0005;
    @(negedge clk);
    check_fault("R10 first", 32'h0001_2000, 32'h0, 32'h0000_0005, 5'd2, 1'b0);
    flt_result = 3'd4; flt_vaddr = 32'h0003_4000; flt_store = 1'b1;
    @(negedge clk);
    check_fault("R10 second", 32'h0003_4000, 32'h0, 32'h0000_0005, 5'd1, 1'b0);
    flt_strobe = 1'b0;
    @(negedge clk);
    chk("R10 pulse ends", {31'd0, exc_valid}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_addr_err();
    t_miss();
    t_invalid();
    t_dirty();
    t_hold();
    t_back_to_back();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule